// File: doc/BRIEF.md
# Majority-Vote UART Receiver

This block receives asynchronous serial frames. A tick input, pulsed sixteen times per bit period, paces it. The line input passes through a two-stage synchronizer. While the receiver is idle, the first tick that sees the line low becomes tick 1 of a candidate start bit. From then on a tick counter runs through each bit period. Three samples taken in the middle of every bit are reduced to one bit value by majority vote. The receiver accepts the start bit only if that vote reads low.

The eight data bits are shifted into a first-stage register, least significant bit first, and are followed by a stop bit. The frame completes on the vote of the stop bit. With the FIFO-enable input low, the byte moves to a holding register, the full flag sets and an interrupt pulses for one cycle. A host read strobe clears the full flag. With the FIFO-enable input high, the byte is presented on a write port for an external queue and the full flag is held clear.

Top module: `mv_uart_rx`

## Requirements
- R1: A bit period is 16 ticks. The idle tick that first sees the line low is tick 1 of the start bit, and every later bit begins on the tick after the previous bit's 16th tick.
- R2: Each bit value is the majority of the line samples taken on ticks 7, 8 and 9 of that bit, so one disturbed sample among the three leaves the result unchanged.
- R3: If the start-bit vote reads high, the receiver returns to idle and produces no frame: no interrupt, no FIFO write, and no change to the full flag.
- R4: A frame is one start bit (low), eight data bits sent least significant bit first, and one stop bit. The frame completes on tick 9 of the stop bit.
- R5: With `fifo_en` low and `buf_full` clear, a completed frame loads `buf_data`, sets `buf_full`, and pulses `irq` high for exactly one cycle on the same clock edge.
- R6: With `fifo_en` high, a completed frame pulses `fifo_wr` for one cycle with the byte on `fifo_wdata`. `irq` does not pulse and `buf_data` does not change. `buf_full` reads 0 from the cycle after `fifo_en` is seen high.
- R7: `frame_err` is updated on every completed frame: 1 if the stop-bit vote read low, 0 if it read high.
- R8: A one-cycle `rd_strobe` clears both `buf_full` and `overrun` on the next clock edge.
- R9: If a frame completes with `fifo_en` low while `buf_full` is set and no read strobe is present, `overrun` sets, `buf_data` keeps its old byte and `irq` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| fifo_en | input | 1 | Route frames to the FIFO write port |
| rd_strobe | input | 1 | Host read of the holding register |
| buf_data | output | 8 | Holding register contents |
| buf_full | output | 1 | Holding register holds unread data |
| irq | output | 1 | One-cycle receive interrupt |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| fifo_wdata | output | 8 | Byte for the FIFO |
| frame_err | output | 1 | Stop bit of last frame voted low |
| overrun | output | 1 | Frame lost because the holding register was full |

## Verification
A counter or bit-index error changes which ticks are sampled. It shows up at the ports as a shifted or corrupted byte in `buf_data` or `fifo_wdata` as soon as the frame completes, about nine ticks into the stop bit. A wrong majority function is exposed by frames with one inverted sample on ticks 7, 8 or 9. The byte they produce differs from the byte that was sent. A broken start qualifier shows up as an interrupt after a short low pulse on an idle line. Flag errors in the holding stage show up within one clock of the completing frame or the read strobe, as a wrong `buf_full`, `overrun` or pulse count.

// File: rtl/mv_uart_pkg.sv
// Package: shared constants and the frame state type for the receiver.
// Assumes a fixed 8-bit frame with one stop bit.
package mv_uart_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/mv_bit_sampler.sv
// Bit sampler: counts oversampling ticks within a bit period and votes on
// three mid-bit samples. Assumes OSR is a power of two and at least 8; the
// counter is held at zero while `active` is low.
module mv_bit_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic active,
    output logic vote_stb,
    output logic vote,
    output logic bit_end
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OSR/2 - 2);
    localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OSR/2);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt;
    logic             s_a;
    logic             s_b;
    logic             step;

    assign step = active && tick;

    // Tick position inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Capture the first two of the three vote samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (step) begin
            if (cnt == SMP_A) s_a <= rxd;
            if (cnt == SMP_B) s_b <= rxd;
        end
    end

    // Third sample is live; the vote is valid when vote_stb is high.
    always_comb begin
        vote     = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
        vote_stb = step && (cnt == SMP_C);
        bit_end  = step && (cnt == LAST);
    end
endmodule

// File: rtl/mv_frame_ctrl.sv
// Frame control: qualifies the start bit, shifts data bits in LSB first and
// emits a one-cycle completion pulse on the stop-bit vote. Assumes `rxd` is
// already synchronous to `clk`.
module mv_frame_ctrl
    import mv_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              vote_stb,
    input  logic              vote,
    input  logic              bit_end,
    output logic              active,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              stop_bad
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_t        state;
    logic [IDX_W-1:0] bit_idx;
    logic             go;

    // A low line on an idle tick opens a candidate start bit.
    always_comb begin
        go     = (state == ST_IDLE) && tick && !rxd;
        active = (state != ST_IDLE) || go;
    end

    // Frame sequencing, shift register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_idx    <= '0;
            frame_data <= '0;
            frame_done <= 1'b0;
            stop_bad   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) state <= ST_START;
                end
                ST_START: begin
                    if (vote_stb && vote) begin
                        state <= ST_IDLE;
                    end else if (bit_end) begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (vote_stb) frame_data <= {vote, frame_data[DATA_W-1:1]};
                    if (bit_end) begin
                        if (bit_idx == LAST_IDX) state <= ST_STOP;
                        else                     bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (vote_stb) begin
                        frame_done <= 1'b1;
                        stop_bad   <= ~vote;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mv_hold_buf.sv
// Holding stage: second buffer with full flag, interrupt and overrun, plus a
// bypass to an external FIFO write port. Assumes frame_done is a one-cycle
// pulse.
module mv_hold_buf
    import mv_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              stop_bad,
    input  logic              fifo_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_full,
    output logic              irq,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              frame_err,
    output logic              overrun
);
    // Route each completed frame and maintain the host-visible flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data   <= '0;
            buf_full   <= 1'b0;
            irq        <= 1'b0;
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            irq     <= 1'b0;
            fifo_wr <= 1'b0;
            if (rd_strobe) begin
                buf_full <= 1'b0;
                overrun  <= 1'b0;
            end
            if (fifo_en) buf_full <= 1'b0;
            if (frame_done) begin
                frame_err <= stop_bad;
                if (fifo_en) begin
                    fifo_wr    <= 1'b1;
                    fifo_wdata <= frame_data;
                end else if (buf_full && !rd_strobe) begin
                    overrun <= 1'b1;
                end else begin
                    buf_data <= frame_data;
                    buf_full <= 1'b1;
                    irq      <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mv_uart_rx.sv
// Top: synchronizes the serial line and chains sampler, frame control and
// holding stage. Assumes `tick` pulses for one clock, 16 times per bit, and
// never on two consecutive clocks.
module mv_uart_rx
    import mv_uart_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              fifo_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] buf_data,
    output logic              buf_full,
    output logic              irq,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              frame_err,
    output logic              overrun
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;
    logic                   active;
    logic                   vote_stb;
    logic                   vote;
    logic                   bit_end;
    logic                   frame_done;
    logic [DATA_W-1:0]      frame_data;
    logic                   stop_bad;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign rxd_s = sync_q[SYNC_STAGES-1];

    mv_bit_sampler #(.OSR(OSR)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rxd      (rxd_s),
        .active   (active),
        .vote_stb (vote_stb),
        .vote     (vote),
        .bit_end  (bit_end)
    );

    mv_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd_s),
        .vote_stb   (vote_stb),
        .vote       (vote),
        .bit_end    (bit_end),
        .active     (active),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .stop_bad   (stop_bad)
    );

    mv_hold_buf u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .stop_bad   (stop_bad),
        .fifo_en    (fifo_en),
        .rd_strobe  (rd_strobe),
        .buf_data   (buf_data),
        .buf_full   (buf_full),
        .irq        (irq),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );
endmodule

// File: rtl/mv_uart_rx_chk.sv
// Checker: temporal properties of the holding stage flags and pulses.
module mv_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       rd_strobe,
    input logic       frame_done,
    input logic [7:0] buf_data,
    input logic       buf_full,
    input logic       irq,
    input logic       fifo_wr,
    input logic       overrun
);
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_with_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_full);

    assert_fifo_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr);

    assert_fifo_holds_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |=> !buf_full);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> (!buf_full && !overrun));

    assert_full_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !rd_strobe) |=> $stable(buf_data));
endmodule

bind mv_uart_rx mv_uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .rd_strobe  (rd_strobe),
    .frame_done (frame_done),
    .buf_data   (buf_data),
    .buf_full   (buf_full),
    .irq        (irq),
    .fifo_wr    (fifo_wr),
    .overrun    (overrun)
);

// File: tb/tb_mv_uart_rx.sv
module tb_mv_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic [7:0] data;
        logic       stop;
        logic       fifo;
        logic [4:0] gl;
    } vec_t;

    // byte, stop level, fifo route, inverted tick in each data bit (0 = none)
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 1'b1, 1'b0, 5'd0},
        '{8'h3C, 1'b1, 1'b0, 5'd8},
        '{8'h01, 1'b0, 1'b0, 5'd7},
        '{8'h80, 1'b1, 1'b1, 5'd9},
        '{8'hFF, 1'b1, 1'b0, 5'd0},
        '{8'h00, 1'b0, 1'b1, 5'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       fifo_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] buf_data;
    logic       buf_full;
    logic       irq;
    logic       fifo_wr;
    logic [7:0] fifo_wdata;
    logic       frame_err;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int fifo_cnt = 0;

    mv_uart_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd),
        .fifo_en    (fifo_en),
        .rd_strobe  (rd_strobe),
        .buf_data   (buf_data),
        .buf_full   (buf_full),
        .irq        (irq),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick every fourth clock, changed on falling edges.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Count output pulses.
    always @(posedge clk) begin
        if (rst_n && irq)     irq_cnt++;
        if (rst_n && fifo_wr) fifo_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Wait until one tick has been consumed, then return on a falling edge.
    task automatic tick_pass();
        @(posedge clk);
        while (tick !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic val, input int gl);
        for (int t = 1; t <= 16; t++) begin
            rxd = (t == gl) ? ~val : val;
            tick_pass();
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop,
                              input int gl, input int start_gl);
        tick_pass();
        send_bit(1'b0, start_gl);
        for (int i = 0; i < 8; i++) send_bit(d[i], gl);
        send_bit(stop, 0);
        send_bit(1'b1, 0);
        send_bit(1'b1, 0);
    endtask

    task automatic read_pulse();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset buf_full", buf_full, 0);
        check("R5 reset irq", irq, 0);
        check("R6 reset fifo_wr", fifo_wr, 0);
        check("R7 reset frame_err", frame_err, 0);
        check("R9 reset overrun", overrun, 0);

        // Table walk: R1 R2 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            int i0, f0;
            v = VECS[k];
            fifo_en = v.fifo;
            i0 = irq_cnt;
            f0 = fifo_cnt;
            send_frame(v.data, v.stop, int'(v.gl), 0);
            check("R7 frame_err", frame_err, int'(!v.stop));
            if (!v.fifo) begin
                check("R4 R2 buf_data", buf_data, v.data);
                check("R5 buf_full", buf_full, 1);
                check("R5 irq pulses", irq_cnt - i0, 1);
                check("R5 no fifo write", fifo_cnt - f0, 0);
                read_pulse();
                check("R8 read clears full", buf_full, 0);
            end else begin
                check("R4 R2 fifo_wdata", fifo_wdata, v.data);
                check("R6 fifo writes", fifo_cnt - f0, 1);
                check("R6 no irq", irq_cnt - i0, 0);
                check("R6 full clear", buf_full, 0);
            end
        end
        fifo_en = 1'b0;

        // R9 overrun keeps old byte; R8 read clears both flags
        begin
            int i0;
            i0 = irq_cnt;
            send_frame(8'h5A, 1'b1, 0, 0);
            send_frame(8'hC3, 1'b1, 0, 0);
            check("R9 overrun set", overrun, 1);
            check("R9 old byte kept", buf_data, 8'h5A);
            check("R9 single irq", irq_cnt - i0, 1);
            read_pulse();
            check("R8 overrun cleared", overrun, 0);
            check("R8 full cleared", buf_full, 0);
        end

        // R3 short low pulse on idle line is rejected
        begin
            int i0, f0;
            i0 = irq_cnt;
            f0 = fifo_cnt;
            tick_pass();
            rxd = 1'b0;
            repeat (6) tick_pass();
            rxd = 1'b1;
            repeat (200) tick_pass();
            check("R3 no irq", irq_cnt - i0, 0);
            check("R3 no fifo write", fifo_cnt - f0, 0);
            check("R3 full untouched", buf_full, 0);
            // line is high again: a normal frame must still be received
            send_frame(8'h69, 1'b1, 0, 0);
            check("R3 recovers", buf_data, 8'h69);
            read_pulse();
        end

        // R2 start bit with one high sample at tick 8 still qualifies
        send_frame(8'h96, 1'b1, 0, 8);
        check("R2 start vote", buf_data, 8'h96);
        check("R1 full after frame", buf_full, 1);

        // R6 raising fifo_en clears a pending full flag, data untouched
        @(negedge clk);
        fifo_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 fifo_en clears full", buf_full, 0);
        check("R6 buf_data unchanged", buf_data, 8'h96);
        fifo_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule